// File: doc/BRIEF.md
# Per-CPU Interrupt Signalling Interface

This block sits between a shared interrupt distributor and a single processor. Each cycle the distributor offers one candidate: the most urgent pending interrupt for this processor, as an ID and an 8-bit priority, where a lower number means more urgent. The interface compares that candidate against a software-programmed priority threshold and against the priority of the interrupt the processor is already servicing. It raises the processor's request line only when the candidate beats both.

Software uses a small register bus. It reads an acknowledge register to claim the candidate. That read returns the ID, tells the distributor through a sideband pulse to mark the ID active, and pushes the ID's priority onto a nesting stack, so that priority becomes the new running priority. Software later writes the same ID to a completion register. That write pops the stack and pulses the sideband to mark the ID inactive. Because claiming and completing are separate steps, a strictly more urgent interrupt can preempt a handler that is still running, and the nesting unwinds in order.

Bus accesses are single-cycle strobes. Read data is registered and appears on the cycle after the strobe. The register index is a 3-bit word address: 0 control, 1 priority threshold, 2 acknowledge (read), 3 completion (write), 4 running priority (read).

Top module: `cpuif_core`

## Requirements
- R1: Bit 0 of the control register (address 0) enables the request line. While it is 0, `irq_out` stays low whatever the candidate.
- R2: The threshold register (address 1) holds 8 bits. `irq_out` can be high only if the candidate priority is numerically below the threshold, so a threshold of 0x00 blocks every priority.
- R3: `irq_out` rises only when a valid candidate's priority is strictly below the running priority and the nesting stack is not full. The line is registered and reflects the inputs one cycle later.
- R4: A read of address 2 with a qualifying candidate returns the candidate ID in `bus_rdata[9:0]` on the next cycle. In that same cycle it pulses `act_set` for one cycle with `act_id` equal to the ID, and the candidate priority becomes the running priority.
- R5: A read of address 2 with no qualifying candidate (no valid candidate, or priority not below both the threshold and the running priority) returns 1023. It produces no `act_set` pulse and leaves the running priority unchanged.
- R6: The running priority is readable at address 4. It equals the priority of the most recent unfinished acknowledge, and 0xFF when nothing is in service.
- R7: A write to address 3 whose data bits [9:0] equal the most recently acknowledged, unfinished ID pops the stack, restores the previous running priority, and pulses `act_clr` for one cycle with `act_id` equal to that ID.
- R8: A completion write with a different ID, or with nothing in service, is ignored: no `act_clr` pulse and no change of running priority.
- R9: With DEPTH (default 4) interrupts nested, the request line stays low and an acknowledge read returns 1023.
- R10: After reset the control enable reads 0, the threshold reads 0x00, the running priority reads 0xFF, and `irq_out`, `act_set`, `act_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Single-cycle register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| irq_out | output | 1 | Interrupt request to the processor |
| act_set | output | 1 | Pulse: mark `act_id` active |
| act_clr | output | 1 | Pulse: mark `act_id` inactive |
| act_id | output | 10 | ID for the sideband pulses |

## Verification
The bench sweeps every candidate priority against several thresholds and with the enable clear. An off-by-one comparison (less-or-equal instead of less) would show up as a request at exactly the threshold or at exactly the running priority. It nests acknowledges until the stack is full, then unwinds them. A design that let an equal priority preempt, restored the wrong running priority on pop, or overflowed the stack would return a wrong ID or running priority in that sequence. Completion writes with a stale ID or with nothing in service are checked to leave the running priority and the sideband untouched, which catches a design that pops on any write.

// File: rtl/cpuif_pkg.sv
// Package: register indices for the per-CPU interrupt interface.
// Assumes a 3-bit word address on the register bus.
package cpuif_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_PMASK = 3'd1,
        REG_ACK   = 3'd2,
        REG_EOI   = 3'd3,
        REG_RUN   = 3'd4
    } cpuif_reg_e;

endpackage

// File: rtl/cpuif_prio_stack.sv
// Nesting stack of acknowledged interrupts, kept as a shift register.
// Entry 0 is the top. Empty entries hold the idle priority (all ones),
// so the top entry's priority is directly the running priority.
// Assumes push and pop are never requested in the same cycle.
module cpuif_prio_stack #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    output logic [ID_W-1:0]   top_id,
    output logic [PRIO_W-1:0] top_prio,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  depth_cnt
);

    logic [ID_W-1:0]   ent_id [DEPTH];
    logic [PRIO_W-1:0] ent_pr [DEPTH];

    // Shift entries down on push, up on pop; refill the bottom with idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_id[i] <= '0;
                ent_pr[i] <= '1;
            end
        end else if (push) begin
            ent_id[0] <= push_id;
            ent_pr[0] <= push_prio;
            for (int i = 1; i < DEPTH; i++) begin
                ent_id[i] <= ent_id[i-1];
                ent_pr[i] <= ent_pr[i-1];
            end
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                ent_id[i] <= ent_id[i+1];
                ent_pr[i] <= ent_pr[i+1];
            end
            ent_id[DEPTH-1] <= '0;
            ent_pr[DEPTH-1] <= '1;
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            depth_cnt <= '0;
        else if (push)
            depth_cnt <= depth_cnt + 1'b1;
        else if (pop)
            depth_cnt <= depth_cnt - 1'b1;
    end

    // Top-of-stack view and occupancy flags.
    always_comb begin
        top_id   = ent_id[0];
        top_prio = ent_pr[0];
        empty    = (depth_cnt == '0);
        full     = (depth_cnt == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/cpuif_gate.sv
// Qualification of the distributor's candidate: valid, more urgent than
// both the threshold and the running priority, and room left to nest.
// Purely combinational; lower priority value means more urgent.
module cpuif_gate #(
    parameter int PRIO_W = 8
) (
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] pmask,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stack_full,
    output logic              hit
);

    // Strict comparisons: equal priority never preempts or passes the mask.
    always_comb begin
        hit = cand_valid && (cand_prio < pmask) && (cand_prio < run_prio)
              && !stack_full;
    end

endmodule

// File: rtl/cpuif_regs.sv
// Software-visible control, threshold and read-data register.
// Assumes single-cycle access strobes; read data is registered and held
// until the next read.
module cpuif_regs
    import cpuif_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              take,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              ctrl_en,
    output logic [PRIO_W-1:0] pmask,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ID_W-1:0] SPURIOUS = '1;

    logic [ID_W-1:0] ack_val;

    // Value returned by an acknowledge read.
    always_comb ack_val = take ? cand_id : SPURIOUS;

    // Control and threshold writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            pmask   <= '0;
        end else if (bus_valid && bus_write) begin
            if (bus_addr == REG_CTRL)  ctrl_en <= bus_wdata[0];
            if (bus_addr == REG_PMASK) pmask   <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Read-data register, loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_valid && !bus_write) begin
            case (bus_addr)
                REG_CTRL:  bus_rdata <= {{(DATA_W-1){1'b0}}, ctrl_en};
                REG_PMASK: bus_rdata <= {{(DATA_W-PRIO_W){1'b0}}, pmask};
                REG_ACK:   bus_rdata <= {{(DATA_W-ID_W){1'b0}}, ack_val};
                REG_RUN:   bus_rdata <= {{(DATA_W-PRIO_W){1'b0}}, run_prio};
                default:   bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/cpuif_core.sv
// Per-CPU interrupt interface top. Gates the distributor's candidate with
// the threshold and running priority, drives the request line, and runs
// the acknowledge / completion protocol with a nesting stack.
// Assumes at most one bus access per cycle.
module cpuif_core
    import cpuif_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              irq_out,
    output logic              act_set,
    output logic              act_clr,
    output logic [ID_W-1:0]   act_id
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              ctrl_en;
    logic [PRIO_W-1:0] pmask;
    logic [PRIO_W-1:0] run_prio;
    logic [ID_W-1:0]   top_id;
    logic              st_empty, st_full;
    logic [CNT_W-1:0]  depth_cnt;
    logic              hit, rd_ack, wr_eoi, take, eoi_ok;

    // Decode the acknowledge and completion strobes.
    always_comb begin
        rd_ack = bus_valid && !bus_write && (bus_addr == REG_ACK);
        wr_eoi = bus_valid &&  bus_write && (bus_addr == REG_EOI);
        take   = rd_ack && hit;
        eoi_ok = wr_eoi && !st_empty && (bus_wdata[ID_W-1:0] == top_id);
    end

    cpuif_gate #(.PRIO_W(PRIO_W)) u_gate (
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .pmask      (pmask),
        .run_prio   (run_prio),
        .stack_full (st_full),
        .hit        (hit)
    );

    cpuif_prio_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .pop       (eoi_ok),
        .push_id   (cand_id),
        .push_prio (cand_prio),
        .top_id    (top_id),
        .top_prio  (run_prio),
        .empty     (st_empty),
        .full      (st_full),
        .depth_cnt (depth_cnt)
    );

    cpuif_regs #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .take      (take),
        .cand_id   (cand_id),
        .run_prio  (run_prio),
        .ctrl_en   (ctrl_en),
        .pmask     (pmask),
        .bus_rdata (bus_rdata)
    );

    // Registered request line and distributor sideband pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
            act_set <= 1'b0;
            act_clr <= 1'b0;
            act_id  <= '0;
        end else begin
            irq_out <= ctrl_en && hit;
            act_set <= take;
            act_clr <= eoi_ok;
            if (take)        act_id <= cand_id;
            else if (eoi_ok) act_id <= top_id;
        end
    end

endmodule

// File: rtl/cpuif_core_sva.sv
// Checker for cpuif_core: relates the request line, sideband pulses and
// nesting state to the bus strobes that cause them. Attached by bind.
module cpuif_core_sva #(
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [2:0]        bus_addr,
    input logic [PRIO_W-1:0] cand_prio,
    input logic              irq_out,
    input logic              act_set,
    input logic              act_clr,
    input logic              en_q,
    input logic [PRIO_W-1:0] mask_q,
    input logic [PRIO_W-1:0] run_prio,
    input logic [CNT_W-1:0]  depth_cnt
);

    // R1: a cleared enable keeps the line low on the next cycle.
    p_enable_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !irq_out);

    // R2: a raised line implies the candidate was under the threshold.
    p_mask_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($past(cand_prio) < $past(mask_q)));

    // R4: an activation pulse follows an acknowledge read.
    p_set_from_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_set |-> $past(bus_valid && !bus_write && bus_addr == 3'd2));

    // R3: an acknowledge strictly lowers the running priority.
    p_preempt_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_set |-> (run_prio < $past(run_prio)));

    // R7: a deactivation pulse follows a completion write.
    p_clr_from_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_clr |-> $past(bus_valid && bus_write && bus_addr == 3'd3));

    // R7: a completion raises the running priority number back.
    p_pop_restores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_clr |-> (run_prio > $past(run_prio)));

    // R4/R7: the two sideband pulses never coincide.
    p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_set && act_clr));

    // R9: nesting never exceeds the stack depth.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        depth_cnt <= CNT_W'(DEPTH));

    // R6: nothing in service means the idle running priority.
    p_idle_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_cnt == '0) |-> (run_prio == '1));

endmodule

bind cpuif_core cpuif_core_sva #(
    .PRIO_W(PRIO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .cand_prio (cand_prio),
    .irq_out   (irq_out),
    .act_set   (act_set),
    .act_clr   (act_clr),
    .en_q      (ctrl_en),
    .mask_q    (pmask),
    .run_prio  (run_prio),
    .depth_cnt (depth_cnt)
);

// File: tb/cpuif_core_test.sv
`timescale 1ns/100ps
// Bench for cpuif_core: priority sweeps against thresholds, nesting to
// full depth and back, and ignored completions. Drives and samples on
// the falling edge.
module cpuif_core_test;

    localparam int ID_W  = 10;
    localparam int PW    = 8;
    localparam int DEPTH = 4;
    localparam int SPUR  = 1023;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [2:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            cand_valid = 1'b0;
    logic [ID_W-1:0] cand_id = '0;
    logic [PW-1:0]   cand_prio = '1;
    logic            irq_out, act_set, act_clr;
    logic [ID_W-1:0] act_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cpuif_core #(.ID_W(ID_W), .PRIO_W(PW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .irq_out(irq_out), .act_set(act_set), .act_clr(act_clr), .act_id(act_id)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_op(input bit wr, input int addr, input int data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr;
        bus_addr = 3'(addr); bus_wdata = 32'(data);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic set_cand(input bit v, input int id, input int pr);
        @(negedge clk);
        cand_valid = v; cand_id = ID_W'(id); cand_prio = PW'(pr);
        @(negedge clk);
    endtask

    // Read the running priority and compare.
    task automatic chk_run(input string req, input int exp);
        bus_op(1'b0, 4, 0);
        chk(req, int'(bus_rdata), exp);
    endtask

    // Acknowledge and check the returned ID and sideband pulse.
    task automatic ack(input string req, input int exp_id);
        bus_op(1'b0, 2, 0);
        chk(req, int'(bus_rdata), exp_id);
        chk(req, int'(act_set), (exp_id != SPUR) ? 1 : 0);
        if (exp_id != SPUR) chk(req, int'(act_id), exp_id);
    endtask

    // Complete an ID and check the deactivation pulse.
    task automatic eoi(input string req, input int id, input bit exp_pulse);
        bus_op(1'b1, 3, id);
        chk(req, int'(act_clr), int'(exp_pulse));
        if (exp_pulse) chk(req, int'(act_id), id);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        int masks [4] = '{8'h00, 8'h41, 8'h80, 8'hF0};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state.
        chk("R10 irq", int'(irq_out), 0);
        chk("R10 act_set", int'(act_set), 0);
        chk("R10 act_clr", int'(act_clr), 0);
        bus_op(1'b0, 0, 0); chk("R10 ctrl", int'(bus_rdata), 0);
        bus_op(1'b0, 1, 0); chk("R10 mask", int'(bus_rdata), 0);
        chk_run("R10 run", 8'hFF);

        // R1: enable clear keeps the line low for every priority.
        bus_op(1'b1, 1, 8'hF0);
        cand_valid = 1'b1; cand_id = 10'd5;
        for (int p = 0; p < 256; p += 4) begin
            cand_prio = PW'(p);
            @(negedge clk); @(negedge clk);
            chk("R1 disabled", int'(irq_out), 0);
        end

        // R2/R3: sweep every priority against several thresholds.
        bus_op(1'b1, 0, 1);
        foreach (masks[m]) begin
            bus_op(1'b1, 1, masks[m]);
            for (int p = 0; p < 256; p++) begin
                cand_prio = PW'(p);
                @(negedge clk); @(negedge clk);
                chk("R2 mask sweep", int'(irq_out), (p < masks[m]) ? 1 : 0);
            end
        end
        cand_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R3 invalid cand", int'(irq_out), 0);

        // R4/R3: acknowledge and nested preemption.
        bus_op(1'b1, 1, 8'hF0);
        set_cand(1'b1, 37, 8'h80);
        chk("R3 irq idle", int'(irq_out), 1);
        ack("R4 ack 37", 37);
        chk_run("R6 run 80", 8'h80);
        @(negedge clk);
        chk("R3 equal blocked", int'(irq_out), 0);
        set_cand(1'b1, 50, 8'h7F);
        chk("R3 more urgent", int'(irq_out), 1);
        ack("R4 ack 50", 50);
        chk_run("R6 run 7F", 8'h7F);
        set_cand(1'b1, 60, 8'h7F);
        chk("R3 equal running", int'(irq_out), 0);
        ack("R5 equal spurious", SPUR);
        chk_run("R5 run kept", 8'h7F);

        // R8: stale ID ignored; R7: matching ID pops in order.
        eoi("R8 stale id", 37, 1'b0);
        chk_run("R8 run kept", 8'h7F);
        eoi("R7 eoi 50", 50, 1'b1);
        chk_run("R7 run 80", 8'h80);
        eoi("R7 eoi 37", 37, 1'b1);
        chk_run("R7 run idle", 8'hFF);
        eoi("R8 empty", 37, 1'b0);
        chk_run("R8 empty run", 8'hFF);

        // R5: nothing valid, or above threshold, gives the spurious ID.
        set_cand(1'b0, 9, 8'h10);
        ack("R5 no cand", SPUR);
        set_cand(1'b1, 9, 8'hF0);
        ack("R5 at mask", SPUR);
        chk_run("R5 run idle", 8'hFF);

        // R9: fill the nesting stack, then unwind.
        for (int k = 0; k < DEPTH; k++) begin
            set_cand(1'b1, 10 + k, 8'h80 - 8'h20 * k);
            ack("R9 fill", 10 + k);
        end
        set_cand(1'b1, 99, 8'h01);
        chk("R9 full irq", int'(irq_out), 0);
        ack("R9 full spurious", SPUR);
        chk_run("R9 run top", 8'h20);
        for (int k = DEPTH - 1; k >= 0; k--) begin
            eoi("R7 unwind", 10 + k, 1'b1);
            chk_run("R7 unwind run", (k == 0) ? 8'hFF : 8'h80 - 8'h20 * (k - 1));
        end

        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
        end
    end

endmodule